// File: doc/BRIEF.md
# Accumulator Register File with Stepping Counters

This block is the architectural register store of a small accumulator machine. It holds sixteen 8-bit registers. Slot 0 is the accumulator, and a dedicated output presents it at all times. Slots 1 to 7 are plain working registers. Slots 8 to 10 count down by one on a step command, and slots 11 to 13 count up by one. Slot 14 receives return addresses from jump-and-link. Slot 15 packs a software-owned done flag and a hardware zero flag.

A 4-bit index drives one combinational read port. Updates come from several sources:

- a write from the execute stage,
- a step command naming a counter slot,
- a command that clears bit 7 of one of slots 0 to 7,
- a zero-flag update,
- a link write,
- a done-set pulse from the done instruction,
- an external done-clear that lets a test environment start the next program.

Every update is registered and shows on the read port from the cycle after the clock edge that captured it.

Top module: `acc_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all sixteen registers, including the flags, to 0x00.
- R2: `rd_data` shows the register selected by `rd_idx` combinationally, and `acc_q` always shows register 0.
- R3: With `wr_en` high, `wr_data` is stored into register `wr_idx` at the clock edge (indices 0 to 14 store all 8 bits).
- R4: A step command (`step_en`, `step_idx` in 8..10) subtracts one from that register, wrapping from 0x00 to 0xFF.
- R5: A step command with `step_idx` in 11..13 adds one to that register, wrapping from 0xFF to 0x00.
- R6: A step command aimed at indices 0 to 7, 14 or 15 changes no register.
- R7: `clrb_en` with 3-bit `clrb_idx` forces bit 7 of register 0..7 to zero and keeps bits 6:0.
- R8: `link_en` loads `link_data` into register 14; a write-port write to 14 in the same cycle wins.
- R9: Register 15 has done in bit 7 and zero in bit 0, and bits 6:1 read zero. A write to index 15 changes only bits 7 and 0.
- R10: `zero_upd_en` loads `zero_val` into bit 0 of register 15; a write-port write to 15 in the same cycle wins.
- R11: `done_set` sets bit 7 of register 15, and `done_clear` clears it. The priority is done_clear, then a write-port write to 15, then done_set.
- R12: When a write and a step target the same counter register in one cycle, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 8 | Read port data (combinational) |
| acc_q | output | 8 | Accumulator (register 0) |
| wr_en | input | 1 | Execute-stage write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 8 | Write data |
| step_en | input | 1 | Counter step command |
| step_idx | input | 4 | Register to step |
| clrb_en | input | 1 | Clear-bit-7 command |
| clrb_idx | input | 3 | Register 0..7 whose bit 7 is cleared |
| zero_upd_en | input | 1 | Zero-flag update enable |
| zero_val | input | 1 | New zero-flag value |
| link_en | input | 1 | Link write enable |
| link_data | input | 8 | Return address for register 14 |
| done_set | input | 1 | Done instruction executed |
| done_clear | input | 1 | External clear of the done flag |

## Verification
Every update is due exactly one clock edge after the cycle in which it is presented. The read port and the accumulator output add no further delay, because they are combinational.

The bench drives all inputs on the falling edge and lets one rising edge capture them. It then sets `rd_idx` and samples shortly after the next falling edge, well before the following rising edge.

Counters are stepped through more than a full wrap, and each intermediate value is compared with its start value plus or minus the step count, modulo 256. Each sweep over all sixteen indices shows that commands aimed elsewhere left the other registers untouched.

// File: rtl/acc_rf_pkg.sv
package acc_rf_pkg;

   typedef enum logic [1:0] {
      CK_PLAIN = 2'd0,
      CK_DEC   = 2'd1,
      CK_INC   = 2'd2
   } cell_kind_e;

   // Chooses the behaviour of one register slot from its index.
   function automatic cell_kind_e slot_kind(input int idx, input int dec_base,
                                             input int num_dec, input int inc_base,
                                             input int num_inc);
      if (idx >= dec_base && idx < dec_base + num_dec)
         return CK_DEC;
      else if (idx >= inc_base && idx < inc_base + num_inc)
         return CK_INC;
      else
         return CK_PLAIN;
   endfunction

endpackage

// File: rtl/rf_cell.sv
module rf_cell
   import acc_rf_pkg::*;
#(
   parameter int         W    = 8,
   parameter cell_kind_e KIND = CK_PLAIN
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld_en,
   input  logic [W-1:0] ld_data,
   input  logic         step,
   input  logic         clr_msb,
   output logic [W-1:0] q
);

   logic [W-1:0] stepped;

   generate
      if (W < 2) begin : g_bad_width
         $error("rf_cell: W must be at least 2");
      end
      if (KIND == CK_DEC) begin : g_dec
         assign stepped = q - W'(1);
      end else begin : g_up
         assign stepped = q + W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ld_en)
         q <= ld_data;
      else if (step)
         q <= stepped;
      else if (clr_msb)
         q[W-1] <= 1'b0;
   end

   // R3 / R12: a load wins over any other command in the same cycle
   p_load_wins_r12: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> q == $past(ld_data));

   // R7: only the top bit is cleared
   p_clear_msb_r7: assert property (@(posedge clk) disable iff (rst)
      (clr_msb && !ld_en && !step) |=> (!q[W-1] && q[W-2:0] == $past(q[W-2:0])));

   // R6: with no command the register holds
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!ld_en && !step && !clr_msb) |=> $stable(q));

   generate
      if (KIND == CK_DEC) begin : g_chk_dec
         p_dec_step_r4: assert property (@(posedge clk) disable iff (rst)
            (step && !ld_en) |=> q == W'($past(q) - W'(1)));
      end else if (KIND == CK_INC) begin : g_chk_inc
         p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
            (step && !ld_en) |=> q == W'($past(q) + W'(1)));
      end
   endgenerate

endmodule

// File: rtl/rf_flags.sv
module rf_flags #(
   parameter int W        = 8,
   parameter int DONE_BIT = 7,
   parameter int ZERO_BIT = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic         wr_done,
   input  logic         wr_zero,
   input  logic         zero_en,
   input  logic         zero_val,
   input  logic         done_set,
   input  logic         done_clear,
   output logic [W-1:0] q
);

   logic done_q, zero_q;

   generate
      if (DONE_BIT >= W || ZERO_BIT >= W || DONE_BIT == ZERO_BIT) begin : g_bad_bits
         $error("rf_flags: flag bit positions invalid");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         if (done_clear)
            done_q <= 1'b0;
         else if (wr_en)
            done_q <= wr_done;
         else if (done_set)
            done_q <= 1'b1;
         if (wr_en)
            zero_q <= wr_zero;
         else if (zero_en)
            zero_q <= zero_val;
      end
   end

   always_comb begin
      q           = '0;
      q[DONE_BIT] = done_q;
      q[ZERO_BIT] = zero_q;
   end

   // R9: unused bits never read as one
   p_pad_zero_r9: assert property (@(posedge clk)
      $countones(q) <= 2 && (q & ~((W'(1) << DONE_BIT) | (W'(1) << ZERO_BIT))) == '0);

   // R11: external clear always wins
   p_done_clear_r11: assert property (@(posedge clk) disable iff (rst)
      done_clear |=> !q[DONE_BIT]);

   // R10: zero flag holds without an update
   p_zero_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !zero_en) |=> $stable(q[ZERO_BIT]));

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
   import acc_rf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int NUM_GP   = 8,
   parameter int DEC_BASE = 8,
   parameter int NUM_DEC  = 3,
   parameter int INC_BASE = 11,
   parameter int NUM_INC  = 3,
   parameter int LINK_IDX = 14,
   parameter int FLAG_IDX = 15,
   parameter int DONE_BIT = 7,
   parameter int ZERO_BIT = 0,
   localparam int NREGS   = 2 ** ADDR_W,
   localparam int GP_W    = $clog2(NUM_GP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] acc_q,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              step_en,
   input  logic [ADDR_W-1:0] step_idx,
   input  logic              clrb_en,
   input  logic [GP_W-1:0]   clrb_idx,
   input  logic              zero_upd_en,
   input  logic              zero_val,
   input  logic              link_en,
   input  logic [DATA_W-1:0] link_data,
   input  logic              done_set,
   input  logic              done_clear
);

   logic [DATA_W-1:0] regs [NREGS];

   generate
      if (NUM_GP > DEC_BASE || DEC_BASE + NUM_DEC > INC_BASE ||
          INC_BASE + NUM_INC > NREGS || LINK_IDX >= NREGS || FLAG_IDX >= NREGS ||
          LINK_IDX == FLAG_IDX || NUM_GP < 2) begin : g_bad_map
         $error("acc_regfile: register map parameters inconsistent");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_slot
         if (i == FLAG_IDX) begin : g_flags
            logic flag_wr;
            assign flag_wr = wr_en && (wr_idx == ADDR_W'(i));
            rf_flags #(
               .W        (DATA_W),
               .DONE_BIT (DONE_BIT),
               .ZERO_BIT (ZERO_BIT)
            ) u_flags (
               .clk        (clk),
               .rst        (rst),
               .wr_en      (flag_wr),
               .wr_done    (wr_data[DONE_BIT]),
               .wr_zero    (wr_data[ZERO_BIT]),
               .zero_en    (zero_upd_en),
               .zero_val   (zero_val),
               .done_set   (done_set),
               .done_clear (done_clear),
               .q          (regs[i])
            );
         end else begin : g_reg
            localparam cell_kind_e KIND = slot_kind(i, DEC_BASE, NUM_DEC, INC_BASE, NUM_INC);
            logic              wr_hit, ld, stp, clr;
            logic [DATA_W-1:0] ld_val;

            assign wr_hit = wr_en && (wr_idx == ADDR_W'(i));

            if (i == LINK_IDX) begin : g_link
               assign ld     = wr_hit || link_en;
               assign ld_val = wr_hit ? wr_data : link_data;
            end else begin : g_nolink
               assign ld     = wr_hit;
               assign ld_val = wr_data;
            end

            if (KIND != CK_PLAIN) begin : g_step
               assign stp = step_en && (step_idx == ADDR_W'(i));
            end else begin : g_nostep
               assign stp = 1'b0;
            end

            if (i < NUM_GP) begin : g_clr
               assign clr = clrb_en && (clrb_idx == GP_W'(i));
            end else begin : g_noclr
               assign clr = 1'b0;
            end

            rf_cell #(
               .W    (DATA_W),
               .KIND (KIND)
            ) u_cell (
               .clk     (clk),
               .rst     (rst),
               .ld_en   (ld),
               .ld_data (ld_val),
               .step    (stp),
               .clr_msb (clr),
               .q       (regs[i])
            );
         end
      end
   endgenerate

   assign rd_data = regs[rd_idx];
   assign acc_q   = regs[0];

   // R6: a step aimed at the link slot leaves it alone
   p_step_link_r6: assert property (@(posedge clk) disable iff (rst)
      (step_en && step_idx == ADDR_W'(LINK_IDX) && !link_en &&
       !(wr_en && wr_idx == ADDR_W'(LINK_IDX))) |=> $stable(regs[LINK_IDX]));

   // R8: link write lands in the link slot when the write port is elsewhere
   p_link_load_r8: assert property (@(posedge clk) disable iff (rst)
      (link_en && !(wr_en && wr_idx == ADDR_W'(LINK_IDX))) |=> regs[LINK_IDX] == $past(link_data));

   // R1: everything reads zero after reset
   p_reset_acc_r1: assert property (@(posedge clk)
      $past(rst) |-> acc_q == '0);

endmodule

// File: tb/test_acc_regfile.sv
`timescale 1ns/100ps
module test_acc_regfile;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] rd_idx;
   logic [7:0] rd_data, acc_q;
   logic       wr_en;
   logic [3:0] wr_idx;
   logic [7:0] wr_data;
   logic       step_en;
   logic [3:0] step_idx;
   logic       clrb_en;
   logic [2:0] clrb_idx;
   logic       zero_upd_en, zero_val;
   logic       link_en;
   logic [7:0] link_data;
   logic       done_set, done_clear;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_r [16];

   always #2 clk = ~clk;

   acc_regfile i_acc_regfile (
      .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .acc_q(acc_q),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .step_en(step_en), .step_idx(step_idx),
      .clrb_en(clrb_en), .clrb_idx(clrb_idx),
      .zero_upd_en(zero_upd_en), .zero_val(zero_val),
      .link_en(link_en), .link_data(link_data),
      .done_set(done_set), .done_clear(done_clear)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(input int idx, input logic [7:0] exp, input string tag);
      rd_idx = 4'(idx);
      #0.5;
      chk(tag, rd_data, exp);
   endtask

   task automatic sweep(input string tag);
      for (int j = 0; j < 16; j++) rd_chk(j, exp_r[j], tag);
      chk({tag, " acc"}, acc_q, exp_r[0]);
   endtask

   task automatic idle();
      wr_en = 0; step_en = 0; clrb_en = 0; zero_upd_en = 0; link_en = 0;
      done_set = 0; done_clear = 0;
   endtask

   // commands are driven at a falling edge; one rising edge later they are visible
   task automatic edge_();
      @(negedge clk);
      idle();
   endtask

   task automatic do_write(input int idx, input logic [7:0] d);
      wr_en = 1; wr_idx = 4'(idx); wr_data = d;
      edge_();
   endtask

   initial begin
      #150000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle();
      rst = 1; rd_idx = 0; wr_idx = 0; wr_data = 0; step_idx = 0; clrb_idx = 0;
      zero_val = 0; link_data = 0;
      for (int j = 0; j < 16; j++) exp_r[j] = 8'h00;
      // dirty the registers before reset to make the reset observable
      @(negedge clk);
      rst = 0;
      for (int j = 0; j < 15; j++) do_write(j, 8'hA5);
      rst = 1;
      edge_(); edge_();
      rst = 0;
      sweep("R1 reset");

      // R3 / R2: write every ordinary slot with a distinct value
      for (int j = 0; j < 15; j++) begin
         exp_r[j] = 8'((j * 37 + 5) & 255);
         do_write(j, exp_r[j]);
      end
      sweep("R3 write sweep R2");

      // R9: write all ones into the flags slot; only bits 7 and 0 survive
      do_write(15, 8'hFF);
      exp_r[15] = 8'h81;
      rd_chk(15, exp_r[15], "R9 flags pad");
      do_write(15, 8'h7E);
      exp_r[15] = 8'h00;
      rd_chk(15, exp_r[15], "R9 flags pad2");

      // R4 / R5: step each counter through more than a full wrap
      for (int k = 8; k < 14; k++) begin
         logic [7:0] start;
         start = (k < 11) ? 8'h03 : 8'hFA;
         do_write(k, start);
         for (int n = 1; n <= 260; n++) begin
            step_en = 1; step_idx = 4'(k);
            edge_();
            rd_chk(k, (k < 11) ? 8'((start - n) & 255) : 8'((start + n) & 255),
                   (k < 11) ? "R4 decrement" : "R5 increment");
         end
         exp_r[k] = (k < 11) ? 8'((start - 260) & 255) : 8'((start + 260) & 255);
      end
      sweep("R4 R5 after stepping");

      // R6: steps aimed at non-counter slots change nothing
      for (int k = 0; k < 16; k++) begin
         if (k >= 8 && k < 14) continue;
         step_en = 1; step_idx = 4'(k);
         edge_();
      end
      sweep("R6 ignored steps");

      // R7: clear bit 7 of each working register
      for (int k = 0; k < 8; k++) begin
         exp_r[k] = 8'hC0 | 8'(k);
         do_write(k, exp_r[k]);
         clrb_en = 1; clrb_idx = 3'(k);
         edge_();
         exp_r[k] = 8'h40 | 8'(k);
         rd_chk(k, exp_r[k], "R7 clear msb");
      end
      sweep("R7 others unchanged");

      // R8: link write, then link and write port together
      link_en = 1; link_data = 8'h5A;
      edge_();
      exp_r[14] = 8'h5A;
      rd_chk(14, exp_r[14], "R8 link load");
      link_en = 1; link_data = 8'h11; wr_en = 1; wr_idx = 4'd14; wr_data = 8'h22;
      edge_();
      exp_r[14] = 8'h22;
      rd_chk(14, exp_r[14], "R8 write beats link");

      // R10: zero flag
      zero_upd_en = 1; zero_val = 1;
      edge_();
      rd_chk(15, 8'h01, "R10 zero set");
      zero_upd_en = 1; zero_val = 0; wr_en = 1; wr_idx = 4'd15; wr_data = 8'h01;
      edge_();
      rd_chk(15, 8'h01, "R10 write beats zero update");
      zero_upd_en = 1; zero_val = 0;
      edge_();
      rd_chk(15, 8'h00, "R10 zero clear");

      // R11: done flag priorities
      done_set = 1;
      edge_();
      rd_chk(15, 8'h80, "R11 done set");
      edge_();
      rd_chk(15, 8'h80, "R11 done holds");
      done_clear = 1;
      edge_();
      rd_chk(15, 8'h00, "R11 done clear");
      done_set = 1; done_clear = 1;
      edge_();
      rd_chk(15, 8'h00, "R11 clear beats set");
      done_clear = 1; wr_en = 1; wr_idx = 4'd15; wr_data = 8'h80;
      edge_();
      rd_chk(15, 8'h00, "R11 clear beats write");
      done_set = 1; wr_en = 1; wr_idx = 4'd15; wr_data = 8'h00;
      edge_();
      rd_chk(15, 8'h00, "R11 write beats set");
      exp_r[15] = 8'h00;

      // R12: write and step on the same counter
      step_en = 1; step_idx = 4'd9; wr_en = 1; wr_idx = 4'd9; wr_data = 8'h40;
      edge_();
      exp_r[9] = 8'h40;
      rd_chk(9, exp_r[9], "R12 write beats decrement");
      step_en = 1; step_idx = 4'd12; wr_en = 1; wr_idx = 4'd12; wr_data = 8'hFF;
      edge_();
      exp_r[12] = 8'hFF;
      rd_chk(12, exp_r[12], "R12 write beats increment");
      step_en = 1; step_idx = 4'd12;
      edge_();
      exp_r[12] = 8'h00;
      sweep("R12 R5 final sweep");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule